// File: doc/BRIEF.md
# Error-Feedback Dithered DAC Requantizer

This block turns a wide unsigned input sample into a 12-bit code for a DAC, one code for each update strobe. Plain truncation would drop the fractional bits that the DAC cannot show. Here those bits are kept in a small residue register and added to the next sample before it is cut down. The long-run average of the output codes therefore follows the full input resolution, and the quantisation error is pushed toward half the update rate, where an analog filter can remove it.

A fixed three-step dither cycles through minus, zero and plus a fixed amplitude, one step per strobe. The amplitude is a little under three output steps. It keeps the residue path active even when the input's fractional bits are all zero.

Internal sums carry guard bits. A sum below zero gives code 0, and a sum above full scale gives code 4095. In both cases the residue still takes the low bits of the sum before clamping.

Top module: `erfb_requant`

## Requirements
- R1: On a clock edge with `upd_i` high, `code_o` becomes floor(S / 2^F), where S = `smp_i` + residue + dither and F = IN_W - OUT_W (default 4). The code is 12 bits wide.
- R2: On each strobe, the residue becomes the low F bits of the unclamped S, taken as two's complement. The next strobe adds it back.
- R3: The dither takes the values -A, 0, +A in that order, one value per strobe, and then repeats. A defaults to 3*2^F - 1 (47 with the defaults). After reset the first value used is -A.
- R4: If S is negative, `code_o` is 0.
- R5: If floor(S / 2^F) is greater than 4095, `code_o` is 4095.
- R6: `vld_o` is high for exactly the one clock that follows each strobe, and is low at all other times.
- R7: On a cycle without a strobe, `code_o`, the residue and the dither phase all keep their values.
- R8: While `rst_n` is low, `code_o` is 0 and `vld_o` is 0, the residue is cleared, and the dither phase returns to -A.
- R9: With a constant mid-range input, the sum of N codes times 2^F differs from N times the input by less than 2^F, when N is a multiple of 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| upd_i | input | 1 | DAC update strobe, one clock wide |
| smp_i | input | IN_W (16) | Wide unsigned input sample |
| code_o | output | OUT_W (12) | DAC code |
| vld_o | output | 1 | One-clock pulse marking a new code |

## Verification
The assertions check the following on every cycle:
- The valid pulse follows each strobe by one clock, and only a strobe causes it.
- Code, residue and phase hold still between strobes.
- The dither phase stays within its three states and advances by one step on each strobe.

The actual code values depend on the history of strobes, so only the bench's scenarios show them. These scenarios cover:
- the carried residue and the dither order,
- clamping at both ends,
- restart after reset,
- a long-run average that matches the input at sub-LSB resolution.

// File: rtl/erfb_requant.sv
module erfb_requant #(
  parameter int IN_W     = 16,
  parameter int OUT_W    = 12,
  parameter int DITH_AMP = 3 * (2 ** (IN_W - OUT_W)) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_i,
  input  logic [IN_W-1:0]   smp_i,
  output logic [OUT_W-1:0]  code_o,
  output logic              vld_o
);
  localparam int FR = IN_W - OUT_W;
  localparam int SW = IN_W + 2;
  localparam int WW = SW - FR;
  localparam logic signed [SW-1:0] AMP  = SW'(DITH_AMP);
  localparam logic signed [WW-1:0] CMAX = WW'((1 << OUT_W) - 1);

  logic [FR-1:0]          res_q;
  logic [1:0]             ph_q;
  logic signed [SW-1:0]   dith, sum;
  logic signed [WW-1:0]   whole;
  logic [OUT_W-1:0]       sat;

  assign dith  = (ph_q == 2'd0) ? -AMP : (ph_q == 2'd2) ? AMP : '0;
  assign sum   = $signed({2'b00, smp_i}) + $signed({{(SW-FR){1'b0}}, res_q}) + dith;
  assign whole = sum[SW-1:FR];
  assign sat   = (whole < 0) ? '0 : (whole > CMAX) ? CMAX[OUT_W-1:0] : whole[OUT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      ph_q   <= 2'd0;
      code_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= upd_i;
      if (upd_i) begin
        res_q  <= sum[FR-1:0];
        ph_q   <= (ph_q == 2'd2) ? 2'd0 : ph_q + 2'd1;
        code_o <= sat;
      end
    end
  end
endmodule

module erfb_requant_chk #(
  parameter int FR    = 4,
  parameter int OUT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             upd_i,
  input logic [OUT_W-1:0] code_o,
  input logic             vld_o,
  input logic [FR-1:0]    res_q,
  input logic [1:0]       ph_q
);
  a_r6_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i |=> vld_o);
  a_r6_valid_only_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> !vld_o);
  a_r7_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> $stable(code_o));
  a_r7_residue_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> $stable(res_q) && $stable(ph_q));
  a_r3_phase_legal: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q != 2'd3);
  a_r3_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i |=> ph_q == (($past(ph_q) == 2'd2) ? 2'd0 : $past(ph_q) + 2'd1));
endmodule

bind erfb_requant erfb_requant_chk #(.FR(FR), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .upd_i(upd_i), .code_o(code_o),
  .vld_o(vld_o), .res_q(res_q), .ph_q(ph_q)
);

// File: tb/test_erfb_requant.sv
module test_erfb_requant;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd_i = 1'b0;
  logic [15:0] smp_i = '0;
  logic [11:0] code_o;
  logic        vld_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  erfb_requant i_erfb_requant (.clk(clk), .rst_n(rst_n), .upd_i(upd_i),
    .smp_i(smp_i), .code_o(code_o), .vld_o(vld_o));

  localparam int NV = 12;
  localparam logic [15:0] VIN [NV] = '{16'h1000, 16'h1000, 16'h1000,
                                       16'h0000, 16'h0000, 16'h0000,
                                       16'hFFFF, 16'hFFFF, 16'hFFFF,
                                       16'h8008, 16'h8008, 16'h8008};
  localparam int VEXP [NV] = '{253, 256, 259, 0, 0, 3,
                               4093, 4095, 4095, 2046, 2048, 2052};

  function automatic string tag_of(int i);
    if (i == 3) return "R4";
    if (i == 8) return "R5";
    if (i == 1) return "R2";
    if (i == 2) return "R3";
    return "R1";
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe(logic [15:0] v);
    @(negedge clk);
    smp_i = v;
    upd_i = 1'b1;
    @(negedge clk);
    upd_i = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 code at reset", int'(code_o), 0);
    check("R8 valid at reset", int'(vld_o), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      strobe(VIN[i]);
      check(tag_of(i), int'(code_o), VEXP[i]);
      check("R6 valid pulse", int'(vld_o), 1);
      @(negedge clk);
      check("R6 valid drops", int'(vld_o), 0);
    end

    // R7: idle cycles hold code; residue 5 and phase -A survive idle
    repeat (5) @(negedge clk);
    check("R7 code held", int'(code_o), 2052);
    strobe(16'h1000);
    check("R7 residue/phase kept", int'(code_o), 253);

    // R8: reset clears residue and phase, then first strobe matches a fresh start
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 code cleared", int'(code_o), 0);
    rst_n = 1'b1;
    strobe(16'h1000);
    check("R8 restart", int'(code_o), 253);

    // R9: long-run mean over a multiple of 3 strobes
    begin
      int sum = 0;
      int diff;
      for (int k = 0; k < 96; k++) begin
        strobe(16'h1238);
        sum += int'(code_o);
      end
      diff = sum * 16 - 96 * 16'h1238;
      if (diff < 0) diff = -diff;
      check("R9 mean within one LSB", int'(diff < 16), 1);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule